// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Order

This block produces the internal word address for four-beat burst accesses to a synchronous memory. A starting address is captured from the address bus when either of two active-low load strobes is seen. The processor-side strobe counts only while chip enable is active, and the controller-side strobe always counts. After that, a 2-bit beat count steps on every clock edge where the active-low step input is low. The count forms the two low address bits from the captured start, and the upper bits pass unchanged from the captured address.

A static mode input picks the beat order. In linear order the low bits are the start plus the count, modulo 4. In interleaved order the low bits are the start XOR the count. The output changes only on the clock edge that loads or steps the count, so a memory array can index with it directly in the same cycle.

Top module: `burst_seq`

## Requirements
- R1: When `ctl_strb_n` is 0 at a rising edge, `addr_out` equals the sampled `addr_in` after that edge, whatever `chip_en_n` is.
- R2: When `proc_strb_n` is 0 and `chip_en_n` is 0 at a rising edge, `addr_out` equals the sampled `addr_in` after that edge.
- R3: When `proc_strb_n` is 0 and `chip_en_n` is 1 (and `ctl_strb_n` is 1), the strobe has no effect and the address is kept, or steps only if `step_n` is 0.
- R4: With no load and `step_n` = 1 at an edge, `addr_out` does not change.
- R5: With `ilv_mode` = 0 (linear), beat k (k = 0..3) has low bits equal to (start + k) mod 4. Example: start 2 gives 2, 3, 0, 1.
- R6: With `ilv_mode` = 1 (interleaved), beat k has low bits equal to start XOR k. Example: start 1 gives 1, 0, 3, 2.
- R7: Bits above bit 1 of `addr_out` stay equal to the loaded address for the whole burst, with no carry out of the low two bits.
- R8: After the fourth beat, a further step returns to the starting address, and the same four-address pattern repeats.
- R9: A load strobe in the same cycle as `step_n` = 0 loads the new address and restarts the count at zero. The load takes priority over the step.
- R10: `rst` = 1 at a rising edge clears the address and the count, so `addr_out` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | Starting address bus |
| proc_strb_n | input | 1 | Processor-side load strobe, active low, gated by chip enable |
| ctl_strb_n | input | 1 | Controller-side load strobe, active low, ungated |
| chip_en_n | input | 1 | Chip enable, active low; gates `proc_strb_n` only |
| step_n | input | 1 | Advance the beat count, active low |
| ilv_mode | input | 1 | Order select: 0 linear, 1 interleaved; static |
| addr_out | output | ADDR_W | Current internal word address |

## Verification
The hardest case to reach is a load that coincides with a step in the middle of a burst. The stimulus steps partway into a burst, then asserts the controller strobe with `step_n` still low, and checks that the new start appears with the count back at zero. A second hard case is a start near the top of the address space (all ones). Stepping from there must wrap the low two bits and leave the upper bits unchanged. The interleaved order is checked from two starting offsets, because for start 2 it gives the same sequence as linear order and for start 1 it does not.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_strb_n,
  input  logic              ctl_strb_n,
  input  logic              chip_en_n,
  input  logic              step_n,
  input  logic              ilv_mode,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UW = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        low;
  logic              load;

  assign load = !ctl_strb_n || (!proc_strb_n && !chip_en_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (!step_n) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign low      = ilv_mode ? (base_q[1:0] ^ beat_q) : (base_q[1:0] + beat_q);
  assign addr_out = {base_q[ADDR_W-1:2], low};

  p_ctl_load_r1: assert property (@(posedge clk) disable iff (rst)
    !ctl_strb_n |=> addr_out == $past(addr_in));

  p_proc_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!proc_strb_n && !chip_en_n) |=> addr_out == $past(addr_in));

  p_proc_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_strb_n && !proc_strb_n && chip_en_n && step_n) |=> $stable(addr_out));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_strb_n && (proc_strb_n || chip_en_n) && step_n) |=> $stable(addr_out));

  p_step_lin_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl_strb_n && (proc_strb_n || chip_en_n) && !step_n && !ilv_mode)
      |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

  p_step_ilv_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_strb_n && (proc_strb_n || chip_en_n) && !step_n && ilv_mode)
      |=> addr_out[0] != $past(addr_out[0]));

  p_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_strb_n && (proc_strb_n || chip_en_n))
      |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2]));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> addr_out == '0);

  initial begin
    assert (UW >= 1) else $error("ADDR_W must exceed 2");
  end
endmodule

// File: tb/burst_seq_tb_top.sv
`timescale 1ns/100ps
module burst_seq_tb_top;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          proc_strb_n = 1'b1;
  logic          ctl_strb_n = 1'b1;
  logic          chip_en_n = 1'b1;
  logic          step_n = 1'b1;
  logic          ilv_mode = 1'b0;
  logic [AW-1:0] addr_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [AW-1:0] exp_q[$];
  string         req_q[$];
  bit            done = 0;

  always #2.5 clk = ~clk;

  burst_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .addr_in(addr_in), .proc_strb_n(proc_strb_n),
    .ctl_strb_n(ctl_strb_n), .chip_en_n(chip_en_n), .step_n(step_n),
    .ilv_mode(ilv_mode), .addr_out(addr_out)
  );

  task automatic cyc(input logic r, input logic p_n, input logic c_n, input logic ce_n,
                     input logic st_n, input logic [AW-1:0] a, input logic [AW-1:0] e,
                     input string req);
    @(negedge clk);
    rst = r; proc_strb_n = p_n; ctl_strb_n = c_n; chip_en_n = ce_n; step_n = st_n; addr_in = a;
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_chk++;
      if (addr_out !== e) begin
        n_fail++;
        $display("FAIL %s: addr_out=%h expected=%h", r, addr_out, e);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    cyc(1, 1, 1, 1, 1, 18'h3FFFF, 18'h00000, "R10");
    // R1 controller strobe loads with chip enable inactive
    cyc(0, 1, 0, 1, 1, 18'h12346, 18'h12346, "R1");
    // R5/R7 linear order from start 2
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h12347, "R5");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h12344, "R5");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h12345, "R7");
    // R8 wrap to start
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h12346, "R8");
    // R4 hold
    cyc(0, 1, 1, 1, 1, 18'h00000, 18'h12346, "R4");
    // R3 gated processor strobe ignored
    cyc(0, 0, 1, 1, 1, 18'h0ABC0, 18'h12346, "R3");
    cyc(0, 1, 1, 1, 1, 18'h0ABC0, 18'h12346, "R3");
    // R2 processor strobe with chip enable
    cyc(0, 0, 1, 0, 1, 18'h3FFFF, 18'h3FFFF, "R2");
    // R7 no carry into upper bits
    cyc(0, 1, 1, 0, 0, 18'h00000, 18'h3FFFC, "R7");
    cyc(0, 1, 1, 0, 0, 18'h00000, 18'h3FFFD, "R5");
    // R9 load during step restarts count
    cyc(0, 1, 0, 1, 0, 18'h00101, 18'h00101, "R9");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h00102, "R9");
    // R10 reset mid-burst; switch to interleaved while held
    cyc(1, 1, 1, 1, 0, 18'h00000, 18'h00000, "R10");
    ilv_mode = 1'b1;
    cyc(1, 1, 1, 1, 1, 18'h00000, 18'h00000, "R10");
    // R6 interleaved from start 1
    cyc(0, 1, 0, 0, 1, 18'h00005, 18'h00005, "R1");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h00004, "R6");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h00007, "R6");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h00006, "R6");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h00005, "R8");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h00004, "R8");
    // R6 interleaved from start 2
    cyc(0, 0, 1, 0, 0, 18'h0000A, 18'h0000A, "R9");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h0000B, "R6");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h00008, "R6");
    cyc(0, 1, 1, 1, 0, 18'h00000, 18'h00009, "R6");
    cyc(0, 1, 1, 1, 1, 18'h00000, 18'h00009, "R4");
    @(negedge clk);
    step_n = 1'b1;
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule